// File: doc/BRIEF.md
# Row-Sweep Refresh Command Sequencer

This block performs one refresh of a memory device by opening and closing rows explicitly rather than by sending a single auto-refresh command. A single-cycle start pulse makes it capture its configuration inputs. These are the open-bank status, a mask of the banks allowed to take part, the per-bank or all-bank mode with its target bank, the total row count, the refresh-mode divisor, the number of refresh commands per retention window, and the row increment. The block then emits a stream of bank commands over a valid/ready interface.

The stream starts with a precharge prologue that closes the open banks that take part. A sweep follows: for every row step, each participating bank gets an activate and then a precharge. When the sweep is complete the block raises a one-cycle done pulse. In the same cycle it presents the duration the sequence represents, computed from the precharge and activate timing parameters. It does not enforce device timing; a downstream scheduler spaces the commands.

Top module: `refresh_sweep_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o` and `done_o` are low and `dur_o` is zero.
- R2: The sweep length is computed as the total row count integer-divided by the mode divisor, with that quotient then integer-divided by the per-window command count. A zero divisor of either kind gives a length of zero, which means the sweep has no steps.
- R3: A precharge prologue is needed in per-bank mode only when the target bank is open, and in all-bank mode when any bank is open.
- R4: When the prologue is needed, per-bank mode precharges the target bank only if its mask bit is set. All-bank mode precharges every bank that is both open and enabled, in ascending bank order. Opcode encoding: 0 = precharge, 1 = activate.
- R5: The sweep index starts at zero and advances by the row increment while it is below the sweep length, so the step count is the sweep length divided by the increment, rounded up. An increment of zero is treated as one.
- R6: Each sweep step issues, for each participating bank in ascending order, an activate followed by a precharge to that bank. The participating banks are the target bank in per-bank mode, if its mask bit is set, and every enabled bank in all-bank mode.
- R7: The reported duration is T_RP if the prologue was needed, plus (T_RCD + T_RP) for each sweep step. It is presented on `dur_o` in the cycle `done_o` is high.
- R8: A command offered with `cmd_ready_i` low is held with unchanged bank and opcode until accepted. Exactly one command is consumed per cycle with valid and ready both high, and no command is offered while idle.
- R9: `done_o` is high for exactly one cycle, after which the block is idle. A start pulse received while busy is ignored and does not change the command stream or the duration.
- R10: If no bank participates, the prologue and the sweep issue no commands, but the duration is still accumulated as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| per_bank_i | input | 1 | 1 = per-bank mode, 0 = all-bank mode |
| target_bank_i | input | BANK_W | Target bank for per-bank mode |
| bank_open_i | input | NUM_BANKS | Bank open status |
| bank_en_i | input | NUM_BANKS | Participation mask |
| row_total_i | input | ROW_W | Total row count |
| mode_div_i | input | CNT_W | Refresh-mode divisor |
| ref_per_win_i | input | CNT_W | Refresh commands per window |
| row_step_i | input | ROW_W | Row increment |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_bank_o | output | BANK_W | Command bank index |
| cmd_op_o | output | 1 | Opcode: 0 precharge, 1 activate |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dur_o | output | DUR_W | Accumulated duration |

## Verification
The first command can be offered no earlier than the cycle after the start pulse is registered. After that, each command's timing depends only on the ready handshake. The bench therefore compares commands at acceptance time against a queue built from R2 to R6, rather than at fixed cycle counts. A command is counted as accepted when valid and ready are both seen at the falling edge before a rising edge. The done pulse is checked in the cycle it appears: the queue must be empty, the duration must match R7, and the next falling edge must show the block idle. Ready is driven one time unit after the rising edge and every output is sampled on the falling edge, so the hold check of R8 compares consecutive falling-edge samples.

// File: rtl/refseq_pkg.sv
// Shared types for the row-sweep refresh sequencer.
package refseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_STEP,
        S_ACT,
        S_SPRE,
        S_DONE
    } seq_state_t;

    typedef enum logic {
        OP_PRE = 1'b0,
        OP_ACT = 1'b1
    } seq_op_t;
endpackage

// File: rtl/refseq_rows.sv
// Computes the number of rows covered by one refresh.
// Assumes: inputs are stable while sampled; a zero divisor yields zero rows.
module refseq_rows #(
    parameter int ROW_W = 12,
    parameter int CNT_W = 6
) (
    input  logic [ROW_W-1:0] total_i,
    input  logic [CNT_W-1:0] div_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [ROW_W-1:0] rows_o
);
    logic [ROW_W-1:0] per_mode;

    // Two-stage integer division with zero-divisor guard.
    always_comb begin
        per_mode = '0;
        rows_o   = '0;
        if (div_i != '0 && cnt_i != '0) begin
            per_mode = total_i / ROW_W'(div_i);
            rows_o   = per_mode / ROW_W'(cnt_i);
        end
    end
endmodule

// File: rtl/refseq_lowbit.sv
// Finds the lowest set bit of a mask.
// Assumes: idx_o is meaningful only when any_o is high.
module refseq_lowbit #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
        any_o = |mask_i;
    end
endmodule

// File: rtl/refresh_sweep_seq.sv
// Issues one refresh as a precharge prologue plus an activate/precharge sweep.
// Assumes: a downstream scheduler enforces device timing; commands leave
// through a valid/ready handshake; configuration is captured on start.
module refresh_sweep_seq
    import refseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int CNT_W     = 6,
    parameter int DUR_W     = 20,
    parameter int T_RP      = 5,
    parameter int T_RCD     = 7,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 per_bank_i,
    input  logic [BANK_W-1:0]    target_bank_i,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic [NUM_BANKS-1:0] bank_en_i,
    input  logic [ROW_W-1:0]     row_total_i,
    input  logic [CNT_W-1:0]     mode_div_i,
    input  logic [CNT_W-1:0]     ref_per_win_i,
    input  logic [ROW_W-1:0]     row_step_i,
    output logic                 cmd_valid_o,
    input  logic                 cmd_ready_i,
    output logic [BANK_W-1:0]    cmd_bank_o,
    output logic                 cmd_op_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DUR_W-1:0]     dur_o
);
    localparam logic [DUR_W-1:0] RP_D   = DUR_W'(T_RP);
    localparam logic [DUR_W-1:0] STEP_D = DUR_W'(T_RCD + T_RP);

    seq_state_t             state_q;
    logic [NUM_BANKS-1:0]   pend_q;
    logic [NUM_BANKS-1:0]   sweep_mask_q;
    logic [ROW_W-1:0]       rows_q;
    logic [ROW_W-1:0]       step_q;
    logic [ROW_W:0]         idx_q;
    logic [DUR_W-1:0]       acc_q;

    logic [ROW_W-1:0]       rows_c;
    logic [BANK_W-1:0]      low_idx;
    logic                   low_any;
    logic [NUM_BANKS-1:0]   tgt_onehot;
    logic                   pre_need;
    logic [NUM_BANKS-1:0]   pre_mask_c;
    logic [NUM_BANKS-1:0]   sweep_mask_c;
    logic                   issuing;
    logic                   accept;

    refseq_rows #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_rows (
        .total_i (row_total_i),
        .div_i   (mode_div_i),
        .cnt_i   (ref_per_win_i),
        .rows_o  (rows_c)
    );

    refseq_lowbit #(.N(NUM_BANKS), .IW(BANK_W)) u_low (
        .mask_i (pend_q),
        .idx_o  (low_idx),
        .any_o  (low_any)
    );

    // Decode the start-time prologue need and the bank sets.
    always_comb begin
        tgt_onehot = '0;
        tgt_onehot[target_bank_i] = 1'b1;
        if (per_bank_i) begin
            pre_need     = |(bank_open_i & tgt_onehot);
            pre_mask_c   = pre_need ? (tgt_onehot & bank_en_i) : '0;
            sweep_mask_c = tgt_onehot & bank_en_i;
        end else begin
            pre_need     = |bank_open_i;
            pre_mask_c   = bank_open_i & bank_en_i;
            sweep_mask_c = bank_en_i;
        end
    end

    // Command interface outputs driven from the current state.
    always_comb begin
        issuing     = (state_q == S_PRE) || (state_q == S_ACT) || (state_q == S_SPRE);
        cmd_valid_o = issuing && low_any;
        cmd_bank_o  = low_idx;
        cmd_op_o    = (state_q == S_ACT) ? OP_ACT : OP_PRE;
        accept      = cmd_valid_o && cmd_ready_i;
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_DONE);
        dur_o       = acc_q;
    end

    // Sequencer state, pending banks, sweep index and duration accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            pend_q       <= '0;
            sweep_mask_q <= '0;
            rows_q       <= '0;
            step_q       <= '0;
            idx_q        <= '0;
            acc_q        <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        pend_q       <= pre_mask_c;
                        sweep_mask_q <= sweep_mask_c;
                        rows_q       <= rows_c;
                        step_q       <= (row_step_i == '0) ? ROW_W'(1) : row_step_i;
                        idx_q        <= '0;
                        acc_q        <= pre_need ? RP_D : '0;
                        state_q      <= S_PRE;
                    end
                end
                S_PRE: begin
                    if (!low_any) begin
                        state_q <= S_STEP;
                    end else if (accept) begin
                        pend_q[low_idx] <= 1'b0;
                    end
                end
                S_STEP: begin
                    if (idx_q >= {1'b0, rows_q}) begin
                        state_q <= S_DONE;
                    end else begin
                        pend_q  <= sweep_mask_q;
                        acc_q   <= acc_q + STEP_D;
                        state_q <= S_ACT;
                    end
                end
                S_ACT: begin
                    if (!low_any) begin
                        idx_q   <= idx_q + {1'b0, step_q};
                        state_q <= S_STEP;
                    end else if (accept) begin
                        state_q <= S_SPRE;
                    end
                end
                S_SPRE: begin
                    if (accept) begin
                        pend_q[low_idx] <= 1'b0;
                        state_q         <= S_ACT;
                    end
                end
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_bank_o) && $stable(cmd_op_o));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_valid_o);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(rows_q) && $stable(sweep_mask_q));

    // R6
    act_bank_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_op_o |-> sweep_mask_q[cmd_bank_o]);
endmodule

// File: tb/refresh_sweep_seq_tb.sv
// Self-checking bench: behavioural command queue and duration model,
// compared on every falling edge.
module refresh_sweep_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int BW    = 2;
    localparam int ROW_W = 12;
    localparam int CNT_W = 6;
    localparam int DUR_W = 20;
    localparam int TRP   = 5;
    localparam int TRCD  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic per_bank_i = 1'b0;
    logic [BW-1:0] target_bank_i = '0;
    logic [NB-1:0] bank_open_i = '0;
    logic [NB-1:0] bank_en_i = '0;
    logic [ROW_W-1:0] row_total_i = '0;
    logic [CNT_W-1:0] mode_div_i = '0;
    logic [CNT_W-1:0] ref_per_win_i = '0;
    logic [ROW_W-1:0] row_step_i = '0;
    logic cmd_valid_o;
    logic cmd_ready_i = 1'b1;
    logic [BW-1:0] cmd_bank_o;
    logic cmd_op_o;
    logic busy_o;
    logic done_o;
    logic [DUR_W-1:0] dur_o;

    refresh_sweep_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .CNT_W(CNT_W),
        .DUR_W(DUR_W), .T_RP(TRP), .T_RCD(TRCD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .per_bank_i(per_bank_i),
        .target_bank_i(target_bank_i), .bank_open_i(bank_open_i),
        .bank_en_i(bank_en_i), .row_total_i(row_total_i), .mode_div_i(mode_div_i),
        .ref_per_win_i(ref_per_win_i), .row_step_i(row_step_i),
        .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_bank_o(cmd_bank_o), .cmd_op_o(cmd_op_o), .busy_o(busy_o),
        .done_o(done_o), .dur_o(dur_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    int exp_dur = 0;
    int done_seen = 0;
    bit monitor_on = 1'b0;
    bit prev_stall = 1'b0;
    int prev_bank = 0;
    int prev_op = 0;
    bit after_done = 1'b0;
    bit ready_random = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ready pattern, driven just after the rising edge.
    always @(posedge clk) begin
        cycles++;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        #1 cmd_ready_i = ready_random ? lfsr[0] : 1'b1;
    end

    // Compare the design against the model at every falling edge.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (after_done) begin
                // R9 idle after done pulse
                chk(!busy_o && !done_o, "R9 idle after done", busy_o, 0);
                after_done = 1'b0;
            end
            if (prev_stall) begin
                // R8 hold while stalled
                chk(cmd_valid_o && cmd_bank_o == prev_bank && cmd_op_o == prev_op,
                    "R8 hold", {cmd_op_o, cmd_bank_o}, prev_op * 4 + prev_bank);
            end
            if (cmd_valid_o && cmd_ready_i) begin
                int got;
                got = cmd_op_o * 256 + cmd_bank_o;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4/R6 unexpected command", got, -1);
                end else begin
                    int want;
                    want = exp_q.pop_front();
                    chk(got == want, "R4/R6 command", got, want);
                end
            end
            if (!busy_o) begin
                // R8 quiet when idle
                if (cmd_valid_o) chk(1'b0, "R8 valid while idle", 1, 0);
            end
            if (done_o) begin
                done_seen++;
                chk(exp_q.size() == 0, "R6 queue drained at done", exp_q.size(), 0);
                chk(int'(dur_o) == exp_dur, "R7 duration", dur_o, exp_dur);
                after_done = 1'b1;
            end
            prev_stall = cmd_valid_o && !cmd_ready_i;
            prev_bank  = cmd_bank_o;
            prev_op    = cmd_op_o;
        end
    end

    // Build the expected command list and duration from the requirements.
    task automatic build_model(input bit pb, input int tgt, input int open_m, input int en_m,
                               input int total, input int dv, input int cn, input int step);
        int rows;
        bit need;
        int st;
        exp_q.delete();
        // R2 sweep length
        rows = (dv == 0 || cn == 0) ? 0 : (total / dv) / cn;
        // R3 prologue need
        need = pb ? open_m[tgt] : (open_m != 0);
        exp_dur = need ? TRP : 0;
        // R4 prologue precharges
        if (need) begin
            for (int b = 0; b < NB; b++) begin
                if (pb ? (b == tgt && en_m[b]) : (open_m[b] && en_m[b]))
                    exp_q.push_back(b);
            end
        end
        // R5 step 0 treated as 1
        st = (step == 0) ? 1 : step;
        for (int r = 0; r < rows; r += st) begin
            // R7 per step cost, R10 even with no bank
            exp_dur += TRCD + TRP;
            for (int b = 0; b < NB; b++) begin
                if (pb ? (b == tgt && en_m[b]) : en_m[b]) begin
                    exp_q.push_back(256 + b);   // R6 activate
                    exp_q.push_back(b);         // R6 precharge
                end
            end
        end
    endtask

    task automatic run_case(input string name, input bit pb, input int tgt, input int open_m,
                            input int en_m, input int total, input int dv, input int cn,
                            input int step, input bit rnd, input bit poke_busy);
        int waited;
        build_model(pb, tgt, open_m, en_m, total, dv, cn, step);
        ready_random = rnd;
        done_seen = 0;
        @(posedge clk);
        #2;
        per_bank_i    = pb;
        target_bank_i = BW'(tgt);
        bank_open_i   = NB'(open_m);
        bank_en_i     = NB'(en_m);
        row_total_i   = ROW_W'(total);
        mode_div_i    = CNT_W'(dv);
        ref_per_win_i = CNT_W'(cn);
        row_step_i    = ROW_W'(step);
        start_i       = 1'b1;
        @(posedge clk);
        #2 start_i = 1'b0;
        if (poke_busy) begin
            // R9 start while busy, with different settings
            repeat (3) @(posedge clk);
            #2;
            bank_en_i = '1; row_total_i = 12'd200; mode_div_i = 6'd1; ref_per_win_i = 6'd1;
            per_bank_i = 1'b0; start_i = 1'b1;
            @(posedge clk);
            #2 start_i = 1'b0;
        end
        waited = 0;
        while (done_seen == 0 && waited < 5000) begin
            @(posedge clk);
            waited++;
        end
        repeat (3) @(posedge clk);
        // R9 exactly one done pulse per sequence
        chk(done_seen == 1, {"R9 single done ", name}, done_seen, 1);
        chk(!busy_o, {"R9 back to idle ", name}, busy_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk(!busy_o && !cmd_valid_o && !done_o, "R1 idle in reset", busy_o, 0);
        chk(dur_o == '0, "R1 duration zero", dur_o, 0);
        rst_n = 1'b1;
        monitor_on = 1'b1;
        @(posedge clk);
        #2 chk(!busy_o && dur_o == '0, "R1 idle after reset", busy_o, 0);

        // R3/R4 all-bank with two open banks, R5 step 2
        run_case("allbank", 1'b0, 0, 4'b0101, 4'b1111, 64, 2, 4, 2, 1'b0, 1'b0);
        // R3 per-bank open target, random ready for R8
        run_case("pb_open", 1'b1, 2, 4'b0100, 4'b0100, 48, 1, 8, 4, 1'b1, 1'b0);
        // R3 per-bank closed target: no prologue
        run_case("pb_closed", 1'b1, 1, 4'b1001, 4'b1111, 30, 3, 2, 1, 1'b1, 1'b0);
        // R4/R10 per-bank open target but masked out
        run_case("pb_masked", 1'b1, 3, 4'b1000, 4'b0111, 20, 1, 4, 1, 1'b0, 1'b0);
        // R10 all-bank empty mask
        run_case("empty", 1'b0, 0, 4'b1000, 4'b0000, 40, 2, 2, 3, 1'b0, 1'b0);
        // R2 zero divisor gives zero rows
        run_case("zerodiv", 1'b0, 0, 4'b0011, 4'b1011, 40, 0, 2, 1, 1'b1, 1'b0);
        // R2 quotient rounds to zero
        run_case("tiny", 1'b0, 0, 4'b0000, 4'b1111, 3, 2, 2, 1, 1'b0, 1'b0);
        // R5 zero increment treated as one, non-dividing step elsewhere
        run_case("step0", 1'b0, 0, 4'b0010, 4'b0110, 12, 1, 4, 0, 1'b1, 1'b0);
        run_case("step_odd", 1'b0, 0, 4'b0000, 4'b1001, 70, 1, 10, 3, 1'b0, 1'b0);
        // R9 start while busy ignored
        run_case("busy_poke", 1'b0, 0, 4'b1100, 4'b1110, 32, 2, 2, 2, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule